// File: doc/BRIEF.md
# DRAM Chip-Select Base/Mask Decoder

This block picks which of eight DRAM chip selects owns a physical memory address. Every select has a base register and a mask register. The block compares two slices of the incoming address against the base: a coarse slice that resolves 32-MByte blocks, and a fine slice that supports equal-size module layouts. A set bit in the mask drops the matching address bit from the comparison. A select takes part only while the enable bit in its base register is set.

The address is sampled on each clock edge. One cycle later the block presents a one-hot select vector and a hit flag. When two or more selects match, the one with the lowest index wins. A 32-bit register port writes and reads back all sixteen registers.

Top module: `dram_cs_decode`

## Requirements
- R1: `regAddr[3]` chooses the register kind: 0 is base, 1 is mask. `regAddr[2:0]` chooses the select index. A write happens on a rising clock edge while `regWe` is high. `regRdData` shows the addressed register combinationally.
- R2: In a base register only bits 31:21, 15:9 and 0 store data. In a mask register only bits 29:21 and 15:9 store data. Every other bit reads back as 0, whatever value was written.
- R3: After reset every base and mask register reads 0, and `csSel` and `csHit` are 0.
- R4: A select whose base bit 0 (enable) is 0 never hits, even when its address fields match.
- R5: Coarse field: address bits 35:25 are compared with base bits 31:21. Mask bits 29:21 exclude address bits 33:25. Address bits 35:34 have no mask bits and are always compared.
- R6: Fine field: address bits 19:13 are compared with base bits 15:9. Mask bits 15:9 exclude the matching address bits.
- R7: A select hits only when every unmasked bit in both fields equals its base bit. Address bits outside both fields never affect the result.
- R8: When several selects hit, only the lowest-indexed one is set in `csSel`, so `csSel` is always one-hot or zero.
- R9: `csSel` and `csHit` appear one clock edge after `lookupAddr` is sampled. `csHit` is 1 exactly when some select hits.
- R10: A lookup sampled on the same edge as a register write uses the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register select: bit 3 chooses base or mask, bits 2:0 the select index |
| regWe | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the addressed register |
| lookupAddr | input | 40 | Physical address to decode |
| csSel | output | 8 | One-hot chip select, registered |
| csHit | output | 1 | Some select matched, registered |

## Verification
A register write and an address lookup can happen on the same clock edge. The bench provokes this in two ways. In the directed phase it enables a select while presenting an address that only the new contents would match. In the random phase it mixes writes and lookups on the same cycles. In both cases the expected select is computed from the bench's register model before the model applies that write. The following read-back then confirms that the write still landed.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int CSD_MAX_CS = 8;
  localparam int CSD_IDX_W  = $clog2(CSD_MAX_CS);

  // writable bit patterns of the two register kinds
  localparam logic [31:0] BASE_WMASK = 32'hFFE0_FE01;
  localparam logic [31:0] MASK_WMASK = 32'h3FE0_FE00;

  typedef struct packed {
    logic [CSD_MAX_CS-1:0] wrBase;
    logic [CSD_MAX_CS-1:0] wrMask;
    logic                  rdMask;
    logic [CSD_IDX_W-1:0]  rdIdx;
  } csdStrobes_t;
endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
#(
  parameter int NUM_CS = CSD_MAX_CS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CSD_IDX_W:0] regAddr,
  input  logic              regWe,
  output csdStrobes_t       strb
);
  logic [CSD_IDX_W-1:0] idx;
  logic                 isMask;

  assign idx    = regAddr[CSD_IDX_W-1:0];
  assign isMask = regAddr[CSD_IDX_W];

  always_comb begin
    strb        = '0;
    strb.rdMask = isMask;
    strb.rdIdx  = idx;
    if (regWe && (int'(idx) < NUM_CS)) begin
      if (isMask) strb.wrMask[idx] = 1'b1;
      else        strb.wrBase[idx] = 1'b1;
    end
  end

  // R1: a single write touches at most one register
  a_r1_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrBase, strb.wrMask}));
  // R1: no write strobe without a write request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> ({strb.wrBase, strb.wrMask} == '0));
endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int NUM_CS = CSD_MAX_CS,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  csdStrobes_t       strb,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [NUM_CS-1:0] csSel,
  output logic              csHit
);
  localparam int CO_W = 11;  // address 35:25
  localparam int FI_W = 7;   // address 19:13

  logic [31:0]       baseQ [NUM_CS];
  logic [31:0]       maskQ [NUM_CS];
  logic [NUM_CS-1:0] rawMatch;
  logic [NUM_CS-1:0] pick;
  logic [NUM_CS:0]   lowerHit;
  logic [CO_W-1:0]   coAddr;
  logic [FI_W-1:0]   fiAddr;

  assign coAddr = lookupAddr[35:25];
  assign fiAddr = lookupAddr[19:13];

  generate
    for (genvar k = 0; k < NUM_CS; k++) begin : gSel
      logic [CO_W-1:0] coDiff;
      logic [CO_W-1:0] coIgnore;
      logic [FI_W-1:0] fiDiff;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseQ[k] <= '0;
          maskQ[k] <= '0;
        end else begin
          if (strb.wrBase[k]) baseQ[k] <= regWrData & BASE_WMASK;
          if (strb.wrMask[k]) maskQ[k] <= regWrData & MASK_WMASK;
        end
      end

      assign coDiff   = coAddr ^ baseQ[k][31:21];
      assign coIgnore = {2'b00, maskQ[k][29:21]};
      assign fiDiff   = fiAddr ^ baseQ[k][15:9];
      assign rawMatch[k] = baseQ[k][0]
                         && ((coDiff & ~coIgnore) == '0)
                         && ((fiDiff & ~maskQ[k][15:9]) == '0);

      // lowest index wins
      assign pick[k]         = rawMatch[k] & ~lowerHit[k];
      assign lowerHit[k + 1] = lowerHit[k] | rawMatch[k];

      // R4: a disabled select never drives its output
      a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
        !baseQ[k][0] |=> !csSel[k]);
      // R8: a raw match at k yields a winner at index k or below
      a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
        rawMatch[k] |=> ((csSel & NUM_CS'((2 ** (k + 1)) - 1)) != '0));
    end
  endgenerate

  assign lowerHit[0] = 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSel <= '0;
      csHit <= 1'b0;
    end else begin
      csSel <= pick;
      csHit <= lowerHit[NUM_CS];
    end
  end

  always_comb begin
    regRdData = '0;
    if (int'(strb.rdIdx) < NUM_CS)
      regRdData = strb.rdMask ? maskQ[strb.rdIdx] : baseQ[strb.rdIdx];
  end

  // R8: output stays one-hot or zero
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSel));
  // R9: hit flag agrees with the select vector
  a_r9_hit_agrees: assert property (@(posedge clk) disable iff (!rstN)
    csHit == (csSel != '0));
  // R2: read data never shows a reserved bit
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~(strb.rdMask ? MASK_WMASK : BASE_WMASK)) == '0);
endmodule

// File: rtl/dram_cs_decode.sv
module dram_cs_decode
  import csd_pkg::*;
#(
  parameter int NUM_CS = CSD_MAX_CS,
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [NUM_CS-1:0] csSel,
  output logic              csHit
);
  csdStrobes_t strb;

  csd_ctrl #(.NUM_CS(NUM_CS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  csd_datapath #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .lookupAddr (lookupAddr),
    .csSel      (csSel),
    .csHit      (csHit)
  );
endmodule

// File: tb/sim_dram_cs_decode.sv
module sim_dram_cs_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BW = 32'hFFE0_FE01;
  localparam logic [31:0] MW = 32'h3FE0_FE00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [39:0] lookupAddr = '0;
  logic [7:0]  csSel;
  logic        csHit;

  int checks = 0;
  int errors = 0;
  logic [31:0] mb [8];
  logic [31:0] mm [8];

  dram_cs_decode u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .lookupAddr(lookupAddr),
    .csSel(csSel), .csHit(csHit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {hit, sel} from the register model
  function automatic logic [8:0] expLook(input logic [39:0] a);
    logic [7:0] sel = '0;
    for (int k = 0; k < 8; k++) begin
      logic [10:0] cd = a[35:25] ^ mb[k][31:21];
      logic [6:0]  fd = a[19:13] ^ mb[k][15:9];
      logic ok = mb[k][0] && ((cd & ~{2'b00, mm[k][29:21]}) == '0)
                          && ((fd & ~mm[k][15:9]) == '0);
      if (ok && sel == '0) sel = 8'(1) << k;
    end
    return {sel != '0, sel};
  endfunction

  task automatic wrReg(input int idx, input bit isMask, input logic [31:0] d);
    @(negedge clk);
    regAddr = {isMask, 3'(idx)};
    regWrData = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    if (isMask) mm[idx] = d & MW; else mb[idx] = d & BW;
  endtask

  task automatic look(input string req, input logic [39:0] a);
    logic [8:0] e;
    @(negedge clk);
    lookupAddr = a;
    e = expLook(a);
    @(negedge clk);
    chk(req, {23'd0, csHit, csSel}, {23'd0, e});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] a;
    logic [8:0]  e;
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) begin mb[k] = '0; mm[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3: reset state
    chk("R3 sel", {23'd0, csHit, csSel}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      regAddr = 4'(k);
      #1 chk("R3 regs", regRdData, 32'd0);
    end
    // R2/R1: reserved bits and readback
    wrReg(3, 1'b0, 32'hFFFF_FFFF);
    regAddr = 4'd3; #1 chk("R2 base", regRdData, BW);
    wrReg(3, 1'b1, 32'hFFFF_FFFF);
    regAddr = 4'd11; #1 chk("R2 mask", regRdData, MW);
    wrReg(3, 1'b0, 32'h0); wrReg(3, 1'b1, 32'h0);
    // R4: matching fields but disabled
    wrReg(1, 1'b0, 32'h0040_0400);
    look("R4 disabled", {4'h0, 11'h002, 5'h0, 7'h02, 13'h0});
    // R5/R6/R7: enable and exact match
    wrReg(1, 1'b0, 32'h0040_0401);
    look("R7 exact", {4'h0, 11'h002, 5'h1F, 7'h02, 13'h1ABC});
    look("R5 coarse miss", {4'h0, 11'h003, 5'h0, 7'h02, 13'h0});
    look("R6 fine miss", {4'h0, 11'h002, 5'h0, 7'h03, 13'h0});
    wrReg(1, 1'b1, 32'h3FE0_FE00);
    look("R5 masked", {4'h0, 11'h1FF, 5'h0, 7'h55, 13'h0});
    look("R5 bit34 unmasked", {4'h0, 11'h202, 5'h0, 7'h02, 13'h0});
    look("R5 bit35 unmasked", {4'h0, 11'h402, 5'h0, 7'h02, 13'h0});
    // R8: overlap; cs5 and cs2 identical, cs1 not matching
    wrReg(1, 1'b1, 32'h0);
    wrReg(5, 1'b0, 32'h00A0_0001); wrReg(2, 1'b0, 32'h00A0_0001);
    look("R8 lowest", {4'h0, 11'h005, 5'h0, 7'h00, 13'h0});
    wrReg(2, 1'b0, 32'h00A0_0000);
    look("R8 next", {4'h0, 11'h005, 5'h0, 7'h00, 13'h0});
    // R10: write and lookup on the same edge
    a = {4'h0, 11'h007, 5'h0, 7'h10, 13'h0};
    @(negedge clk);
    lookupAddr = a;
    regAddr = 4'd6; regWrData = 32'h00E0_2001; regWe = 1'b1;
    e = expLook(a);
    @(negedge clk);
    regWe = 1'b0; mb[6] = 32'h00E0_2001;
    chk("R10 old contents", {23'd0, csHit, csSel}, {23'd0, e});
    @(negedge clk);
    chk("R10 new contents", {23'd0, csHit, csSel}, {23'd0, expLook(a)});
    regAddr = 4'd6; #1 chk("R1 readback", regRdData, 32'h00E0_2001);
    // R9/R7: random mix
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 7));
      a = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) != 0) begin
        a[35:25] = mb[k][31:21] ^ (11'($urandom()) & {2'b00, mm[k][29:21]});
        a[19:13] = mb[k][15:9] ^ (7'($urandom()) & mm[k][15:9]);
        if ($urandom_range(0, 4) == 0) a[25 + $urandom_range(0, 10)] ^= 1'b1;
      end
      @(negedge clk);
      lookupAddr = a;
      e = expLook(a);
      if ($urandom_range(0, 2) == 0) begin
        logic [3:0] ra = 4'($urandom());
        logic [31:0] d = $urandom();
        if ($urandom_range(0, 1) == 0) d[0] = 1'b1;
        regAddr = ra; regWrData = d; regWe = 1'b1;
        @(negedge clk);
        regWe = 1'b0;
        if (ra[3]) mm[ra[2:0]] = d & MW; else mb[ra[2:0]] = d & BW;
      end else begin
        @(negedge clk);
      end
      chk("R9 random", {23'd0, csHit, csSel}, {23'd0, e});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule